// File: doc/BRIEF.md
# Two-wire serial EEPROM slave controller

This block is the slave side of a 256-by-8 nonvolatile byte store that sits on a two-wire serial bus. The clock and data lines arrive as raw pins and are resynchronised into the system clock. The block drives the data line only through an open-drain pull-down enable. It recognises start and stop conditions, shifts bytes in on rising clock edges and shifts bytes out after falling edges. It acknowledges a byte only when the transaction was addressed to it. Three strap inputs let up to eight devices share one bus.

A write transaction is start, write-direction select, word address, one data byte, stop. The stop launches a programming phase of fixed length, modelled as a cycle counter. The byte reaches the array only when that phase completes. During the phase, a read-direction select is left unacknowledged, so a master can poll for completion. A matching write-direction select cancels the phase, and the pending byte is then never stored. A read starts from the current address counter; a master that wants a given address first sends a write select and the word address, then a repeated start. Each master acknowledge advances the counter, which wraps from 255 to 0.

Top module: `ee_i2c_slave`

## Requirements
- R1: A falling data line while the clock is high is a start condition and a rising data line while the clock is high is a stop condition; a stop returns the sequencer to idle and releases the data line from any state, including the middle of a byte.
- R2: The first byte after a start is a select word laid out as 1010, then bits equal to sel_i[2], sel_i[1], sel_i[0], then a direction bit (0 = write, 1 = read), sent MSB first; any other value is not acknowledged, and no later byte of that transaction is acknowledged.
- R3: For each accepted received byte, the data line is pulled low (sda_oe = 1) through the ninth clock and released after that clock's falling edge.
- R4: Write select, word address and data byte, followed by stop, store the byte at that address once PROG_CYCLES clock cycles have passed; a second data byte in the same transaction is not acknowledged and is not stored.
- R5: While programming is in progress a matching read select is not acknowledged; after programming has finished it is acknowledged.
- R6: A matching write select that arrives during programming is acknowledged and ends programming at once; the interrupted byte is never stored, and a read select right after it is acknowledged.
- R7: After a read select is acknowledged, the byte at the current address is sent MSB first, with its first bit on the line after the falling edge of the ninth clock; a write select plus word address followed by a repeated start sets that address.
- R8: During the ninth clock of a sent byte the data line is released; a master acknowledge (data low) advances the address, which wraps from 255 to 0, and starts the next byte; a master non-acknowledge leaves the line released until the next start or stop.
- R9: After reset the data line is released and the sequencer is idle and not programming.
- R10: The block changes sda_oe only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sel_i | input | 3 | Device select straps compared with the select word |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The hardest situations to reach are the ones that only exist inside the programming window: the unacknowledged poll and the abort. Neither can be seen directly, because nothing at the ports shows whether programming is still in progress. The bench shortens PROG_CYCLES so that the next transaction after a write stop lands inside the window. After an abort it waits beyond a full window and reads the address back, so the missing store shows up as the old byte. Address wrap is reached by storing bytes at 254, 255 and 0, then reading across the boundary with master acknowledges.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_TXACK,
    S_SKIP
  } ee_state_t;

  typedef enum logic [1:0] {
    K_SEL,
    K_ADDR,
    K_DATA,
    K_EXTRA
  } ee_kind_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level,
  output logic level_q
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-1:0], line_i};
  end

  assign level   = pipe_q[STAGES-1];
  assign level_q = pipe_q[STAGES];
endmodule

// File: rtl/ee_prog_timer.sv
module ee_prog_timer #(
  parameter int CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (abort)               cnt_d = '0;
    else if (launch)         cnt_d = CW'(CYCLES);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1)) && !abort;
endmodule

// File: rtl/ee_store.sv
module ee_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [0:(1<<AW)-1];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave
  import ee_pkg::*;
#(
  parameter int PROG_CYCLES = 2_000_000,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_i,
  output logic       sda_oe
);
  localparam int BW   = 8;
  localparam int CNTW = $clog2(BW + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_l = rst_pipe[1];

  // line conditioning
  logic scl_s, scl_p, sda_s, sda_p;
  ee_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_l), .line_i(scl_i), .level(scl_s), .level_q(scl_p));
  ee_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_l), .line_i(sda_i), .level(sda_s), .level_q(sda_p));

  logic scl_rise, scl_fall, bus_start, bus_stop;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

  // state
  ee_state_t       st_q, st_d;
  ee_kind_t        kind_q, kind_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [BW-1:0]   rsh_q, rsh_d, tsh_q, tsh_d, wdata_q, wdata_d;
  logic [AW-1:0]   addr_q, addr_d, waddr_q, waddr_d;
  logic            rd_q, rd_d, mack_q, mack_d, pend_q, pend_d, oe_d;

  logic            launch, abort, busy, mem_we, addr_inc, sel_hit;
  logic [BW-1:0]   rd_data;

  ee_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_l), .launch(launch), .abort(abort),
    .busy(busy), .done(mem_we));

  ee_store #(.AW(AW), .DW(BW)) u_store (
    .clk(clk), .we(mem_we), .waddr(waddr_q), .wdata(wdata_q),
    .raddr(addr_q), .rdata(rd_data));

  assign sel_hit = (rsh_q[7:4] == DEV_TYPE) && (rsh_q[3:1] == sel_i);

  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    cnt_d    = cnt_q;
    rsh_d    = rsh_q;
    tsh_d    = tsh_q;
    addr_d   = addr_q;
    waddr_d  = waddr_q;
    wdata_d  = wdata_q;
    rd_d     = rd_q;
    mack_d   = mack_q;
    pend_d   = pend_q;
    launch   = 1'b0;
    abort    = 1'b0;
    addr_inc = 1'b0;
    if (bus_stop) begin
      st_d   = S_IDLE;
      launch = pend_q;
      pend_d = 1'b0;
    end else if (bus_start) begin
      st_d   = S_RX;
      kind_d = K_SEL;
      cnt_d  = '0;
      pend_d = 1'b0;
    end else begin
      unique case (st_q)
        S_RX: begin
          if (scl_rise) begin
            rsh_d = {rsh_q[BW-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNTW'(BW)) begin
            cnt_d = '0;
            st_d  = S_SKIP;
            unique case (kind_q)
              K_SEL: begin
                if (sel_hit && rsh_q[0] && !busy) begin
                  st_d = S_ACK;
                  rd_d = 1'b1;
                end else if (sel_hit && !rsh_q[0]) begin
                  st_d   = S_ACK;
                  rd_d   = 1'b0;
                  abort  = busy;
                  kind_d = K_ADDR;
                end
              end
              K_ADDR: begin
                st_d   = S_ACK;
                addr_d = rsh_q[AW-1:0];
                kind_d = K_DATA;
              end
              K_DATA: begin
                st_d    = S_ACK;
                waddr_d = addr_q;
                wdata_d = rsh_q;
                pend_d  = 1'b1;
                kind_d  = K_EXTRA;
              end
              default: st_d = S_SKIP;
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rd_q) begin
              st_d  = S_TX;
              tsh_d = rd_data;
            end else begin
              st_d = S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNTW'(BW - 1)) begin
              st_d = S_TXACK;
            end else begin
              tsh_d = {tsh_q[BW-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        S_TXACK: begin
          if (scl_rise) begin
            mack_d   = ~sda_s;
            addr_inc = ~sda_s;
            if (!sda_s) addr_d = addr_q + 1'b1;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (mack_q) begin
              st_d  = S_TX;
              tsh_d = rd_data;
            end else begin
              st_d = S_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
    oe_d = (st_d == S_ACK) || (st_d == S_TX && !tsh_d[BW-1]);
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q    <= S_IDLE;
      kind_q  <= K_SEL;
      cnt_q   <= '0;
      rsh_q   <= '0;
      tsh_q   <= '0;
      addr_q  <= '0;
      waddr_q <= '0;
      wdata_q <= '0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      pend_q  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      st_q    <= st_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      rsh_q   <= rsh_d;
      tsh_q   <= tsh_d;
      addr_q  <= addr_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
      rd_q    <= rd_d;
      mack_q  <= mack_d;
      pend_q  <= pend_d;
      sda_oe  <= oe_d;
    end
  end
endmodule

// File: rtl/ee_i2c_slave_chk.sv
module ee_i2c_slave_chk
  import ee_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_s,
  input logic          busy,
  input logic          launch,
  input logic          mem_we,
  input logic          abort,
  input logic          addr_inc,
  input logic [AW-1:0] addr,
  input ee_state_t     st,
  input logic          rd_mode
);
  // R10: output moves only while the clock line is low
  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R9: idle sequencer never pulls the line
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  // R2, R8: skipped transaction keeps the line released
  a_r2_skip_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> !sda_oe);

  // R5: no read acknowledge while programming
  a_r5_no_read_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK && busy) |-> !rd_mode);

  // R4: stop-launched programming starts; completing store ends it
  a_r4_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);
  a_r4_store_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !busy);

  // R6: abort ends programming at once and blocks the store
  a_r6_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);
  a_r6_abort_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !mem_we);

  // R8: address advance wraps within AW bits
  a_r8_addr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    addr_inc |=> (addr == AW'($past(addr) + 1'b1)));
endmodule

bind ee_i2c_slave ee_i2c_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s), .busy(busy),
  .launch(launch), .mem_we(mem_we), .abort(abort), .addr_inc(addr_inc),
  .addr(addr_q), .st(st_q), .rd_mode(rd_q));

// File: tb/sim_ee_i2c_slave.sv
`timescale 1ns/1ps
module sim_ee_i2c_slave;
  localparam int PROG = 400;
  localparam int Q    = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] sel = 3'b101;
  logic       sda_oe;
  logic       sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  ee_i2c_slave #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sel_i(sel), .sda_oe(sda_oe));

  int          total = 0;
  int          bad = 0;
  bit          finished = 0;
  string       tag_q [$];
  logic [31:0] exp_q [$];
  logic [31:0] obs_v;
  event        obs_ev;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor: pops expected items in order as results appear
  initial begin
    forever begin
      @(obs_ev);
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard: unexpected item actual=%0h expected=none", obs_v);
      end else begin
        string       t;
        logic [31:0] e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        if (obs_v !== e) begin
          bad++;
          $display("FAIL %s actual=%0h expected=%0h", t, obs_v, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  task automatic expect_v(input string t, input logic [31:0] v);
    tag_q.push_back(t);
    exp_q.push_back(v);
  endtask

  task automatic observe(input logic [31:0] v);
    obs_v = v;
    -> obs_ev;
  endtask

  task automatic qtr();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic start_c();
    sda_m = 1'b1; qtr();
    scl_m = 1'b1; qtr();
    sda_m = 1'b0; qtr();
    scl_m = 1'b0; qtr();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; qtr();
    scl_m = 1'b1; qtr();
    sda_m = 1'b1; qtr();
  endtask

  task automatic bit_c(input logic b, output logic s);
    sda_m = b;    qtr();
    scl_m = 1'b1; qtr();
    s = sda_bus;  qtr();
    scl_m = 1'b0; qtr();
  endtask

  task automatic send(input string t, input logic [7:0] b, input logic ack_exp);
    logic s;
    expect_v(t, {31'd0, ack_exp});
    for (int i = 7; i >= 0; i--) bit_c(b[i], s);
    bit_c(1'b1, s);
    observe({31'd0, ~s});
  endtask

  task automatic recv(input string t, input logic [7:0] d_exp, input logic mack);
    logic       s;
    logic [7:0] d;
    expect_v(t, {24'd0, d_exp});
    for (int i = 7; i >= 0; i--) begin
      bit_c(1'b1, s);
      d[i] = s;
    end
    bit_c(~mack, s);
    observe({24'd0, d});
  endtask

  function automatic logic [7:0] selw(input logic [2:0] c);
    return {4'b1010, c, 1'b0};
  endfunction
  function automatic logic [7:0] selr(input logic [2:0] c);
    return {4'b1010, c, 1'b1};
  endfunction

  task automatic wait_prog();
    repeat (PROG + 60) @(posedge clk);
    #1;
  endtask

  task automatic write_mem(input logic [7:0] a, input logic [7:0] d);
    start_c();
    send("R3", selw(sel), 1'b1);
    send("R3", a, 1'b1);
    send("R4", d, 1'b1);
    stop_c();
    wait_prog();
  endtask

  task automatic set_addr_read(input logic [7:0] a);
    start_c();
    send("R7", selw(sel), 1'b1);
    send("R7", a, 1'b1);
    start_c();
    send("R7", selr(sel), 1'b1);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (8) @(posedge clk);
    #1;
    expect_v("R9", 32'd0);
    observe({31'd0, sda_oe});

    // R4 write, R5 poll while busy then after completion
    start_c();
    send("R2", selw(sel), 1'b1);
    send("R3", 8'h10, 1'b1);
    send("R4", 8'h3C, 1'b1);
    stop_c();
    start_c();
    send("R5", selr(sel), 1'b0);
    stop_c();
    wait_prog();
    start_c();
    send("R5", selr(sel), 1'b1);
    recv("R4", 8'h3C, 1'b0);
    stop_c();

    // R7 random read
    write_mem(8'h44, 8'hC3);
    set_addr_read(8'h44);
    recv("R7", 8'hC3, 1'b0);
    stop_c();

    // R8 sequential read across the wrap
    write_mem(8'hFE, 8'h11);
    write_mem(8'hFF, 8'hA5);
    write_mem(8'h00, 8'h77);
    set_addr_read(8'hFE);
    recv("R8", 8'h11, 1'b1);
    recv("R8", 8'hA5, 1'b1);
    recv("R8", 8'h77, 1'b0);
    qtr();
    expect_v("R8", 32'd0);
    observe({31'd0, sda_oe});
    stop_c();

    // R2 mismatched selects
    start_c();
    send("R2", selw(3'b100), 1'b0);
    send("R2", 8'h00, 1'b0);
    stop_c();
    start_c();
    send("R2", {4'b1011, sel, 1'b0}, 1'b0);
    stop_c();
    sel = 3'b010;
    start_c();
    send("R2", selr(3'b101), 1'b0);
    stop_c();
    start_c();
    send("R2", selr(3'b010), 1'b1);
    recv("R8", 8'h77, 1'b0);
    stop_c();

    // R6 abort of a running program phase
    start_c();
    send("R6", selw(sel), 1'b1);
    send("R6", 8'h10, 1'b1);
    send("R6", 8'h99, 1'b1);
    stop_c();
    start_c();
    send("R6", selw(sel), 1'b1);
    stop_c();
    start_c();
    send("R6", selr(sel), 1'b1);
    recv("R6", 8'h3C, 1'b0);
    stop_c();
    wait_prog();
    set_addr_read(8'h10);
    recv("R6", 8'h3C, 1'b0);
    stop_c();

    // R4 second data byte refused
    start_c();
    send("R4", selw(sel), 1'b1);
    send("R4", 8'h20, 1'b1);
    send("R4", 8'h55, 1'b1);
    send("R4", 8'h66, 1'b0);
    stop_c();
    wait_prog();

    // R1 stop in the middle of a byte
    start_c();
    begin
      logic s;
      bit_c(1'b1, s);
      bit_c(1'b0, s);
      bit_c(1'b1, s);
    end
    stop_c();
    expect_v("R1", 32'd0);
    observe({31'd0, sda_oe});
    set_addr_read(8'h20);
    recv("R1", 8'h55, 1'b0);
    stop_c();

    repeat (20) @(posedge clk);
    #1;
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
    end
    report();
  end
endmodule